// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block is the digital timing controller for one half-bridge of external N-channel MOSFETs driven by current-mode gate drivers. A single phase input says which switch should conduct (1 = high side, 0 = low side). For each switch, the sequencer drives four signals to the analog driver: a current enable, a direction (source or sink), a current select and a Miller clamp enable. Between one switch finishing its turn-off and the other starting its turn-on, it inserts a deadtime. After a switch is fully on, it raises a blanking window that masks the overcurrent comparator.

Four timing values set the controlled-current window, the turn-off boost segment, the deadtime and the blanking window. All are counted in clock cycles. A gate current level code is also supplied. All five values are captured into shadow registers when a commutation starts, so a sequence always runs with one consistent set of values. An overcurrent that is seen while a switch is fully on and no blanking is active latches a fault. The fault turns the conducting switch off and keeps both switches off until the fault is cleared.

The current select encoding is 00 = programmed level, 01 = maximum, 10 = small holding limit. An inactive switch shows enable 0, direction 0, select 00 and clamp 1.

Top module: `hb_gate_seq`

## Requirements
- R1: While reset is held and after it is released with `enable` low, both enables are 0, both clamps are 1, both selects are 00, and `blank`, `fault` and `gate_ilvl` are 0.
- R2: When a command is taken with neither switch on, both switches stay off for the deadtime. The target switch then sources current with select 00 and its clamp released for the controlled-current time.
- R3: When the turn-on window ends, the switch stays enabled and sourcing. The low side uses select 01 (unlimited) and the high side uses select 10 (holding limit).
- R4: A command for the opposite phase, taken while a switch is on, makes that switch sink current with its clamp released for the controlled-current time. Select is 01 for the first boost-time cycles of that window and 00 for the remaining cycles.
- R5: When the turn-off window ends, that switch's clamp is engaged and its enable drops. The deadtime then follows, and after it the turn-on of the opposite switch (as in R2).
- R6: `blank` is 1 for exactly the blanking time, starting with the first cycle after the turn-on window, and is 0 at all other times.
- R7: A boost time larger than the controlled-current time saturates to it, so the whole turn-off window uses select 01.
- R8: A controlled-current time or deadtime of 0 behaves as 1 cycle.
- R9: The phase input is sampled only while idle or while a switch is steadily on. A phase change that comes and goes during a sequence has no effect.
- R10: The two switches are never enabled in the same cycle.
- R11: `ocp` that is high while a switch is steadily on and `blank` is 0 sets `fault`. The fault starts that switch's turn-off (as in R4) and then holds both switches off, with the phase input ignored, until a `fault_clr` pulse. `ocp` during blanking is ignored.
- R12: Timing or level inputs changed during a sequence do not affect that sequence. They apply from the next commutation.
- R13: `gate_ilvl` shows the current level code captured at the start of the most recent commutation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Allows commands to be sampled |
| phase | input | 1 | Requested conducting switch: 1 high side, 0 low side |
| ocp | input | 1 | Overcurrent comparator output |
| fault_clr | input | 1 | Clears a latched fault while idle |
| cfg_igate | input | IW | Gate current level code |
| cfg_tcc | input | TW | Controlled-current time in cycles |
| cfg_tboost | input | TW | Turn-off boost time in cycles |
| cfg_tdead | input | TW | Deadtime in cycles |
| cfg_tblank | input | TW | Blanking time in cycles |
| hs_en | output | 1 | High-side current generator enable |
| hs_src | output | 1 | High-side direction: 1 source, 0 sink |
| hs_sel | output | 2 | High-side current select |
| hs_clamp | output | 1 | High-side Miller clamp enable |
| ls_en | output | 1 | Low-side current generator enable |
| ls_src | output | 1 | Low-side direction: 1 source, 0 sink |
| ls_sel | output | 2 | Low-side current select |
| ls_clamp | output | 1 | Low-side Miller clamp enable |
| blank | output | 1 | Overcurrent masking window |
| fault | output | 1 | Latched overcurrent fault |
| gate_ilvl | output | IW | Captured gate current level |

## Verification
A command or `ocp` presented before a rising edge is acted on at that edge, so the first cycle of the new sequence is visible one cycle later. Each window then lasts exactly its programmed count: turn-off, then deadtime, then turn-on, then blanking. The bench drives and samples on the falling edge. It compares every output in every cycle of a sequence against a profile built from the requirements, with the first comparison one cycle after the stimulus. A fault shows up one cycle after `ocp`, and a fault clear takes effect one cycle after the pulse. A new command is sampled in the cycle after the clear.

// File: rtl/hb_gate_seq.sv
module hb_gate_seq #(
  parameter int TW = 8,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          phase,
  input  logic          ocp,
  input  logic          fault_clr,
  input  logic [IW-1:0] cfg_igate,
  input  logic [TW-1:0] cfg_tcc,
  input  logic [TW-1:0] cfg_tboost,
  input  logic [TW-1:0] cfg_tdead,
  input  logic [TW-1:0] cfg_tblank,
  output logic          hs_en,
  output logic          hs_src,
  output logic [1:0]    hs_sel,
  output logic          hs_clamp,
  output logic          ls_en,
  output logic          ls_src,
  output logic [1:0]    ls_sel,
  output logic          ls_clamp,
  output logic          blank,
  output logic          fault,
  output logic [IW-1:0] gate_ilvl
);

  localparam logic [TW-1:0] ONE = TW'(1);
  localparam logic [1:0] SEL_PROG = 2'b00;
  localparam logic [1:0] SEL_MAX  = 2'b01;
  localparam logic [1:0] SEL_HOLD = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_TOFF, S_DEAD, S_TON, S_ON} st_t;

  st_t           st;
  logic          side, tgt;
  logic [TW-1:0] cnt, bcnt;
  logic [TW-1:0] sh_tcc, sh_tbo, sh_tdead, sh_tblank;
  logic [IW-1:0] sh_ig;

  logic [TW-1:0] tcc_in;
  logic          ocp_hit, start, act, src_act;
  logic [1:0]    sel_act;

  assign tcc_in  = (cfg_tcc == '0) ? ONE : cfg_tcc;
  assign ocp_hit = (st == S_ON) && (bcnt == '0) && ocp;
  assign start   = enable && !fault &&
                   ((st == S_IDLE) || ((st == S_ON) && !ocp_hit && (phase != side)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_tcc    <= ONE;
      sh_tbo    <= '0;
      sh_tdead  <= ONE;
      sh_tblank <= '0;
      sh_ig     <= '0;
    end else if (start) begin
      sh_tcc    <= tcc_in;
      sh_tbo    <= (cfg_tboost > tcc_in) ? tcc_in : cfg_tboost;
      sh_tdead  <= (cfg_tdead == '0) ? ONE : cfg_tdead;
      sh_tblank <= cfg_tblank;
      sh_ig     <= cfg_igate;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      side  <= 1'b0;
      tgt   <= 1'b0;
      cnt   <= '0;
      bcnt  <= '0;
      fault <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (fault) begin
            if (fault_clr) fault <= 1'b0;
          end else if (start) begin
            tgt <= phase;
            st  <= S_DEAD;
            cnt <= '0;
          end
        end
        S_ON: begin
          if (bcnt != '0) bcnt <= bcnt - ONE;
          if (ocp_hit) begin
            fault <= 1'b1;
            st    <= S_TOFF;
            cnt   <= '0;
          end else if (start) begin
            tgt <= phase;
            st  <= S_TOFF;
            cnt <= '0;
          end
        end
        S_TOFF: begin
          if (cnt == sh_tcc - ONE) begin
            cnt <= '0;
            st  <= fault ? S_IDLE : S_DEAD;
          end else cnt <= cnt + ONE;
        end
        S_DEAD: begin
          if (cnt == sh_tdead - ONE) begin
            cnt  <= '0;
            st   <= S_TON;
            side <= tgt;
          end else cnt <= cnt + ONE;
        end
        S_TON: begin
          if (cnt == sh_tcc - ONE) begin
            cnt  <= '0;
            st   <= S_ON;
            bcnt <= sh_tblank;
          end else cnt <= cnt + ONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign act     = (st == S_TOFF) || (st == S_TON) || (st == S_ON);
  assign src_act = (st != S_TOFF);

  always_comb begin
    case (st)
      S_TOFF:  sel_act = (cnt < sh_tbo) ? SEL_MAX : SEL_PROG;
      S_TON:   sel_act = SEL_PROG;
      default: sel_act = side ? SEL_HOLD : SEL_MAX;
    endcase
  end

  assign hs_en     = act && side;
  assign hs_src    = hs_en && src_act;
  assign hs_sel    = hs_en ? sel_act : SEL_PROG;
  assign hs_clamp  = !hs_en;
  assign ls_en     = act && !side;
  assign ls_src    = ls_en && src_act;
  assign ls_sel    = ls_en ? sel_act : SEL_PROG;
  assign ls_clamp  = !ls_en;
  assign blank     = (st == S_ON) && (bcnt != '0);
  assign gate_ilvl = sh_ig;

endmodule

// File: rtl/hb_gate_seq_chk.sv
module hb_gate_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hs_en,
  input logic       hs_src,
  input logic [1:0] hs_sel,
  input logic       ls_en,
  input logic       ls_src,
  input logic [1:0] ls_sel,
  input logic       blank,
  input logic       fault
);

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

  assert_hs_limited_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en && hs_src) |-> (hs_sel != 2'b01));

  assert_ls_unlimited_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ls_sel != 2'b10);

  assert_hs_turnon_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> (hs_src && hs_sel == 2'b00));

  assert_ls_turnon_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> (ls_src && ls_sel == 2'b00));

  assert_hs_boost_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en && !hs_src && hs_sel == 2'b00) |=> !(hs_en && !hs_src && hs_sel == 2'b01));

  assert_ls_boost_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_en && !ls_src && ls_sel == 2'b00) |=> !(ls_en && !ls_src && ls_sel == 2'b01));

  assert_blank_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> ((hs_en && hs_src && hs_sel != 2'b00) || (ls_en && ls_src && ls_sel != 2'b00)));

  assert_fault_nosource_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !(hs_src || ls_src));

  assert_fault_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !hs_en && !ls_en) |=> (!hs_en && !ls_en));

endmodule

bind hb_gate_seq hb_gate_seq_chk u_chk (.*);

// File: tb/sim_hb_gate_seq.sv
module sim_hb_gate_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, phase = 1'b0, ocp = 1'b0, fault_clr = 1'b0;
  logic [3:0] cfg_igate = '0;
  logic [7:0] cfg_tcc = 8'd1, cfg_tboost = '0, cfg_tdead = 8'd1, cfg_tblank = '0;
  logic hs_en, hs_src, hs_clamp, ls_en, ls_src, ls_clamp, blank, fault;
  logic [1:0] hs_sel, ls_sel;
  logic [3:0] gate_ilvl;

  int checks = 0, fails = 0, cyc = 0;
  bit cur_on = 0, cur = 0;

  always #10 clk = ~clk;

  hb_gate_seq u0 (.*);

  // {flags[2:0] (bit0 phase glitch, bit1 cfg change, bit2 ocp in blank), tgt, tcc, tboost, tdead, tblank, igate}
  localparam logic [39:0] VEC [8] = '{
    {3'd0, 1'b1, 8'd5, 8'd2, 8'd3, 8'd4, 4'd3},
    {3'd0, 1'b0, 8'd4, 8'd1, 8'd2, 8'd3, 4'd7},
    {3'd0, 1'b1, 8'd3, 8'd9, 8'd1, 8'd0, 4'd1},
    {3'd0, 1'b0, 8'd0, 8'd0, 8'd0, 8'd2, 4'd15},
    {3'd0, 1'b1, 8'd6, 8'd6, 8'd4, 8'd5, 4'd2},
    {3'd1, 1'b0, 8'd4, 8'd2, 8'd2, 8'd2, 4'd6},
    {3'd2, 1'b1, 8'd4, 8'd1, 8'd2, 8'd3, 4'd9},
    {3'd4, 1'b0, 8'd3, 8'd1, 8'd1, 8'd4, 4'd5}
  };

  function automatic logic [15:0] mk(bit act, bit sd, bit src, logic [1:0] sel,
                                     bit bl, bit flt, logic [3:0] ig);
    logic [4:0] on_f, hs_f, ls_f;
    on_f = {1'b1, src, sel, 1'b0};
    hs_f = (act && sd)  ? on_f : 5'b00001;
    ls_f = (act && !sd) ? on_f : 5'b00001;
    return {hs_f, ls_f, bl, flt, ig};
  endfunction

  task automatic cmp(logic [15:0] e, string tag);
    logic [15:0] g;
    g = {hs_en, hs_src, hs_sel, hs_clamp, ls_en, ls_src, ls_sel, ls_clamp, blank, fault, gate_ilvl};
    checks++;
    if (g !== e) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, g, e);
    end
  endtask

  task automatic run_cmd(logic [39:0] v);
    logic [2:0] fl; bit tg; int tc, tbo, td, tb; logic [3:0] ig; int tce, tde, tbe;
    string tag;
    tag = "R2 R3 R4 R5 R6 R7 R8 R13";
    {fl, tg} = v[39:36];
    tc = v[35:28]; tbo = v[27:20]; td = v[19:12]; tb = v[11:4]; ig = v[3:0];
    tce = (tc == 0) ? 1 : tc;
    tde = (td == 0) ? 1 : td;
    tbe = (tbo > tce) ? tce : tbo;
    enable = 1; phase = tg;
    cfg_tcc = 8'(tc); cfg_tboost = 8'(tbo); cfg_tdead = 8'(td); cfg_tblank = 8'(tb); cfg_igate = ig;
    if (cur_on)
      for (int i = 0; i < tce; i++) begin
        @(negedge clk); cmp(mk(1, cur, 0, (i < tbe) ? 2'b01 : 2'b00, 0, 0, ig), tag);
      end
    for (int i = 0; i < tde; i++) begin
      @(negedge clk); cmp(mk(0, 0, 0, 2'b00, 0, 0, ig), tag);
    end
    for (int i = 0; i < tce; i++) begin
      @(negedge clk); cmp(mk(1, tg, 1, 2'b00, 0, 0, ig), fl != 0 ? "R9 R12" : tag);
      if (fl[0] && i == 0) phase = !tg;
      if (fl[0] && i == 1) phase = tg;
      if (fl[1] && i == 0) begin
        cfg_tcc = 8'd1; cfg_tdead = 8'd1; cfg_tblank = 8'd0; cfg_igate = 4'd0;
      end
    end
    for (int i = 0; i < tb + 2; i++) begin
      @(negedge clk); cmp(mk(1, tg, 1, tg ? 2'b10 : 2'b01, i < tb, 0, ig), fl != 0 ? "R9 R11 R12" : tag);
      if (fl[2] && i == 0) ocp = 1;
      if (fl[2] && i == 1) ocp = 0;
    end
    cur_on = 1; cur = tg;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp(mk(0, 0, 0, 2'b00, 0, 0, 4'd0), "R1 in reset");
    rst_n = 1;
    repeat (2) @(negedge clk);
    cmp(mk(0, 0, 0, 2'b00, 0, 0, 4'd0), "R1 after release");

    for (int k = 0; k < 8; k++) run_cmd(VEC[k]);

    // R11: fault from the steady low side (tcc 3, tboost 1, level 5)
    ocp = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ocp = 0;
      cmp(mk(1, 0, 0, (i < 1) ? 2'b01 : 2'b00, 0, 1, 4'd5), "R11 fault turn-off");
    end
    phase = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); cmp(mk(0, 0, 0, 2'b00, 0, 1, 4'd5), "R11 fault hold");
    end
    fault_clr = 1;
    @(negedge clk); fault_clr = 0;
    cmp(mk(0, 0, 0, 2'b00, 0, 0, 4'd5), "R11 fault clear");
    cur_on = 0;
    run_cmd({3'd0, 1'b1, 8'd2, 8'd1, 8'd2, 8'd1, 4'd4});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule